// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block holds a parallel word in two stages. A storage register samples the parallel input whenever a one-cycle capture strobe is seen. A separate shift register can be filled from that storage register, forced to zero, or moved one place toward its top stage on a one-cycle shift strobe. On a shift, the serial input enters stage 0 and the serial output is always the top stage.

Because the input word is held in its own register, the producer can present and capture a new word at any time. The consumer decides when to move the held word into the shifter and how to clock it out.

Everything runs on one system clock. The strobes and the active-low controls are qualified enables sampled on its rising edge.

Driving load and clear low together is not a legal request. The block resolves it deterministically, with clear winning, and raises a flag for one cycle to report it.

Top module: `latched_piso`

## Requirements
- R1: After synchronous reset, both the storage register and the shift register are all zeros, `ser_out` is 0 and `bad_combo` is 0.
- R2: On a clock edge where `cap_stb` is 1, the storage register takes `par_in`. With `cap_stb` at 0, changes on `par_in` have no effect on the storage register.
- R3: On an edge where `shf_stb` is 1 and both `load_n` and `clear_n` are 1, stage n takes stage n-1 and stage 0 takes `ser_in`.
- R4: On an edge where `load_n` is 0 and `clear_n` is 1, the shift register takes the storage register's contents, whatever `shf_stb` is.
- R5: On an edge where `clear_n` is 0, the shift register becomes all zeros, whatever `shf_stb` and `load_n` are.
- R6: On an edge where `shf_stb` is 0 and both `load_n` and `clear_n` are 1, the shift register keeps its value.
- R7: When `load_n` and `clear_n` are both 0 on an edge, clear takes priority and `bad_combo` is 1 in the following cycle. At all other times `bad_combo` is 0.
- R8: When a capture and a load happen on the same edge, the shift register receives the storage value from before that capture.
- R9: `ser_out` equals the top stage (bit W-1, with bit 0 the serial entry stage). It shows the result of a load, clear or shift in the cycle right after the edge that performed it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | W (8) | Parallel word to capture |
| cap_stb | input | 1 | One-cycle capture strobe for the storage register |
| shf_stb | input | 1 | One-cycle shift strobe |
| load_n | input | 1 | Active-low transfer from storage to shift register |
| clear_n | input | 1 | Active-low clear of the shift register |
| ser_in | input | 1 | Serial data entering stage 0 |
| ser_out | output | 1 | Top stage of the shift register |
| bad_combo | output | 1 | One-cycle flag: load and clear were requested together |

## Verification
The hardest situation to reach is a capture and a load on the same edge. Only the serial output is visible, so the value the load really took would otherwise be hidden. The stimulus first captures one word and then, on a single edge, captures a second word while loading. It then clocks out all W bits, which must show the first word. A later load must expose the second word. Every full word readout also shifts a known fill pattern in, and a second readout returns that pattern, so shifting is checked along with the readout path.

// File: rtl/lpiso_pkg.sv
package lpiso_pkg;

    localparam int unsigned DEF_WIDTH = 8;

    // Operation applied to the shift register on one clock edge
    typedef enum logic [1:0] {
        SR_HOLD  = 2'd0,
        SR_SHIFT = 2'd1,
        SR_LOAD  = 2'd2,
        SR_CLEAR = 2'd3
    } sr_op_e;

    typedef struct packed {
        sr_op_e op;
        logic   conflict;
    } sr_cmd_t;

    // Clear outranks load, load outranks shift
    function automatic sr_op_e pick_op(input logic load_n,
                                       input logic clear_n,
                                       input logic shf);
        sr_op_e r;
        if (!clear_n)     r = SR_CLEAR;
        else if (!load_n) r = SR_LOAD;
        else if (shf)     r = SR_SHIFT;
        else              r = SR_HOLD;
        return r;
    endfunction

endpackage

// File: rtl/lpiso_capture.sv
module lpiso_capture #(
    parameter int unsigned W = lpiso_pkg::DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (cap) q <= d;
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        cap |=> (q == $past(d)));

    p_hold_store_r2: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(q));

endmodule

// File: rtl/lpiso_decode.sv
module lpiso_decode (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_n,
    input  logic                clear_n,
    input  logic                shf,
    output lpiso_pkg::sr_cmd_t  cmd,
    output logic                conflict_q
);
    import lpiso_pkg::*;

    always_comb begin
        cmd.op       = pick_op(load_n, clear_n, shf);
        cmd.conflict = ~load_n & ~clear_n;
    end

    always_ff @(posedge clk) begin
        if (rst) conflict_q <= 1'b0;
        else     conflict_q <= cmd.conflict;
    end

    p_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (!load_n && !clear_n) |=> conflict_q);

    p_flag_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (load_n || clear_n) |=> !conflict_q);

endmodule

// File: rtl/lpiso_shift_core.sv
module lpiso_shift_core #(
    parameter int unsigned W = lpiso_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  lpiso_pkg::sr_op_e op,
    input  logic [W-1:0]     ld,
    input  logic             sin,
    output logic [W-1:0]     sr
);
    import lpiso_pkg::*;

    logic [W-1:0] nxt;

    // One next-state selector per stage; stage 0 takes the serial input
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic shift_src;
        if (i == 0) begin : g_entry
            assign shift_src = sin;
        end else begin : g_chain
            assign shift_src = sr[i-1];
        end

        always_comb begin
            case (op)
                SR_CLEAR: nxt[i] = 1'b0;
                SR_LOAD:  nxt[i] = ld[i];
                SR_SHIFT: nxt[i] = shift_src;
                default:  nxt[i] = sr[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= nxt;
    end

    p_shift_chain_r3: assert property (@(posedge clk) disable iff (rst)
        (op == SR_SHIFT) |=> (sr[W-1:1] == $past(sr[W-2:0])));

    p_shift_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (op == SR_SHIFT) |=> (sr[0] == $past(sin)));

endmodule

// File: rtl/latched_piso.sv
module latched_piso #(
    parameter int unsigned W = lpiso_pkg::DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] par_in,
    input  logic         cap_stb,
    input  logic         shf_stb,
    input  logic         load_n,
    input  logic         clear_n,
    input  logic         ser_in,
    output logic         ser_out,
    output logic         bad_combo
);
    import lpiso_pkg::*;

    localparam int unsigned TOP = W - 1;

    logic [W-1:0] store_q;
    logic [W-1:0] sr_q;
    sr_cmd_t      cmd;

    lpiso_capture #(.W(W)) u_capture (
        .clk (clk),
        .rst (rst),
        .cap (cap_stb),
        .d   (par_in),
        .q   (store_q)
    );

    lpiso_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .load_n     (load_n),
        .clear_n    (clear_n),
        .shf        (shf_stb),
        .cmd        (cmd),
        .conflict_q (bad_combo)
    );

    lpiso_shift_core #(.W(W)) u_core (
        .clk (clk),
        .rst (rst),
        .op  (cmd.op),
        .ld  (store_q),
        .sin (ser_in),
        .sr  (sr_q)
    );

    assign ser_out = sr_q[TOP];

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> (sr_q == '0));

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !load_n) |=> (sr_q == $past(store_q)));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && !shf_stb) |=> $stable(sr_q));

    p_out_entry_r9: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && shf_stb) |=> (ser_out == $past(sr_q[TOP-1])));

endmodule

// File: tb/latched_piso_test.sv
module latched_piso_test;

    localparam int W = 8;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] par_in = '0;
    logic         cap_stb = 1'b0;
    logic         shf_stb = 1'b0;
    logic         load_n = 1'b1;
    logic         clear_n = 1'b1;
    logic         ser_in = 1'b0;
    logic         ser_out;
    logic         bad_combo;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_piso #(.W(W)) uut (
        .clk(clk), .rst(rst), .par_in(par_in), .cap_stb(cap_stb),
        .shf_stb(shf_stb), .load_n(load_n), .clear_n(clear_n),
        .ser_in(ser_in), .ser_out(ser_out), .bad_combo(bad_combo)
    );

    // Inputs change and outputs are sampled at the falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] got,
                         input logic [W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Reads all stages (top first) while shifting `fill` in; afterwards the
    // register holds `fill`
    task automatic read_word(input logic [W-1:0] fill, output logic [W-1:0] got);
        for (int i = W - 1; i >= 0; i--) begin
            got[i]  = ser_out;
            ser_in  = fill[i];
            shf_stb = 1'b1;
            step();
        end
        shf_stb = 1'b0;
        ser_in  = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] w;
        logic [W-1:0] fill;
        step(); step();
        rst = 1'b0;
        step();

        // R1 reset state
        check("R1 ser_out", {{(W-1){1'b0}}, ser_out}, '0);
        check("R1 bad_combo", {{(W-1){1'b0}}, bad_combo}, '0);
        read_word(8'h00, w);
        check("R1 shift reg", w, '0);
        load_n = 1'b0; step(); load_n = 1'b1;
        read_word(8'h00, w);
        check("R1 storage", w, '0);

        // Sweep every word: capture, ignored input change, load with shift
        for (int v = 0; v < (1 << W); v++) begin
            fill = W'(v) ^ 8'hA5;
            par_in = W'(v); cap_stb = 1'b1; step();
            cap_stb = 1'b0; par_in = ~W'(v); step();           // R2 ignore
            load_n = 1'b0; shf_stb = 1'b1; step();              // R4 override
            load_n = 1'b1; shf_stb = 1'b0;
            check("R9 top stage after load", {{(W-1){1'b0}}, ser_out},
                  {{(W-1){1'b0}}, W'(v) >> (W-1)});
            read_word(fill, w);
            check("R2/R4 loaded word", w, W'(v));
            read_word(8'h00, w);
            check("R3 shifted-in word", w, fill);
        end

        // R5 clear overrides shift
        read_word(8'hFF, w);
        clear_n = 1'b0; shf_stb = 1'b1; step();
        clear_n = 1'b1; shf_stb = 1'b0;
        check("R5 ser_out after clear", {{(W-1){1'b0}}, ser_out}, '0);
        read_word(8'h00, w);
        check("R5 cleared word", w, '0);

        // R6 hold without strobe
        read_word(8'h3C, w);
        repeat (5) step();
        read_word(8'h00, w);
        check("R6 held word", w, 8'h3C);

        // R7 load and clear together
        par_in = 8'hC3; cap_stb = 1'b1; step(); cap_stb = 1'b0;
        load_n = 1'b0; clear_n = 1'b0; step();
        load_n = 1'b1; clear_n = 1'b1;
        check("R7 flag raised", {{(W-1){1'b0}}, bad_combo}, 8'h01);
        check("R7 ser_out", {{(W-1){1'b0}}, ser_out}, '0);
        step();
        check("R7 flag drops", {{(W-1){1'b0}}, bad_combo}, '0);
        read_word(8'h00, w);
        check("R7 clear wins", w, '0);

        // R8 capture and load on the same edge
        par_in = 8'h5A; cap_stb = 1'b1; step();
        par_in = 8'h81; load_n = 1'b0; step();
        cap_stb = 1'b0; load_n = 1'b1;
        read_word(8'h00, w);
        check("R8 old storage loaded", w, 8'h5A);
        load_n = 1'b0; step(); load_n = 1'b1;
        read_word(8'h00, w);
        check("R8 new storage later", w, 8'h81);

        // R1 reset mid-run clears both stages
        read_word(8'hEE, w);
        rst = 1'b1; step(); rst = 1'b0;
        read_word(8'h00, w);
        check("R1 reset shift reg", w, '0);
        load_n = 1'b0; step(); load_n = 1'b1;
        read_word(8'h00, w);
        check("R1 reset storage", w, '0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule